// File: doc/BRIEF.md
# Extended-Precision Result Rounder

This block sits behind an arithmetic stage that produces an 80-bit extended-precision result together with a few extra low-order bits. It rounds that result to a destination precision selected by a 2-bit field (full extended, double-width mantissa or single-width mantissa) in one of four rounding directions selected by a second 2-bit field. The result stays in the 80-bit container. The extended exponent range is kept, and the mantissa bits below the selected width are cleared.

The word format is sign at bit 79, a 15-bit exponent with bias 16383 at bits 78:64, and a 64-bit mantissa at bits 63:0 whose integer bit (bit 63) is stored explicitly. The extra input bits continue the mantissa below bit 0. Normal inputs are assumed to have the integer bit set. An all-ones exponent marks an infinity (mantissa zero) or a NaN, and these pass through untouched. A zero exponent with any nonzero mantissa or extra bits is a denormal, which is flushed to a signed zero.

The unit has two pipeline stages. The first stage classifies the operand and decides whether to add one unit in the last kept place. The second stage applies that increment, renormalises after a carry, and handles overflow. It accepts a new operand every cycle.

Top module: `rnd80_unit`

## Requirements
- R1: With precision 00 and direction 00, an input with no nonzero bits below the mantissa comes out bit-for-bit unchanged with all three flags low.
- R2: Precision 01 keeps the top 24 mantissa bits (63:40), 10 keeps the top 53 (63:11), and 00 or 11 keeps all 64. Result mantissa bits below the kept width are zero.
- R3: Direction 00 rounds to nearest. Half-way cases (guard bit set, all lower bits zero) round so that the last kept bit becomes 0.
- R4: Direction 01 truncates toward zero: the kept bits are never incremented, and overflow is never raised.
- R5: Direction 10 increments the magnitude only of negative inexact values, and direction 11 only of positive inexact values.
- R6: When the increment carries out of the mantissa, the result mantissa is 8000_0000_0000_0000 (hex) and the exponent rises by one.
- R7: When that carry takes the exponent to 7FFF, the result is a correctly signed infinity (exponent 7FFF, mantissa 0), and overflow and inexact are both set.
- R8: Inexact is set exactly when a discarded bit (mantissa or extra bits below the kept width) is nonzero.
- R9: An input with exponent 7FFF (infinity or NaN) comes out unchanged for any precision and direction, with all flags low.
- R10: An input with exponent 0 and nonzero mantissa or extra bits gives a zero of the same sign, with underflow and inexact set. A true zero comes out unchanged with no flags.
- R11: The output strobe rises exactly two cycles after the input strobe, and operands may be presented on back-to-back cycles.
- R12: While reset is low and just after it, the output strobe and all three flags are low, and reset drops any operand in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_val | input | 80 | Extended-precision operand |
| in_ext | input | GUARD_W | Extra mantissa bits below bit 0 of in_val |
| in_prec | input | 2 | Destination precision: 00/11 extended, 01 single, 10 double |
| in_rnd | input | 2 | Direction: 00 nearest, 01 zero, 10 minus inf, 11 plus inf |
| out_valid | output | 1 | Result strobe |
| out_val | output | 80 | Rounded result |
| out_inexact | output | 1 | Discarded bits were nonzero |
| out_overflow | output | 1 | Rounding carried the exponent past its maximum |
| out_underflow | output | 1 | Denormal input flushed to zero |

## Verification
The result value, the strobe and all three flags for an operand are due together two clock edges after it is presented. The bench streams the vector table one operand per cycle. At each falling edge it compares the outputs for the operand driven two steps earlier and only then drives the next one, so every comparison lands in the cycle the pipeline delivers. A separate single-operand run checks that the strobe is low one cycle after input, high on the second and low again on the third. The bound checker uses a cycle counter since reset to compare each output against the inputs two cycles back.

// File: rtl/rnd80_pkg.sv
// Shared widths and types for the extended-precision rounder.
// Assumes the 80-bit word is sign | 15-bit exponent | 64-bit explicit mantissa.
package rnd80_pkg;

    localparam int EXP_W = 15;
    localparam int MAN_W = 64;
    localparam int VAL_W = 1 + EXP_W + MAN_W;

    localparam logic [EXP_W-1:0] EXP_TOP = '1;
    localparam logic [EXP_W-1:0] EXP_BIG = EXP_TOP - 1'b1;

    // Operand class, settled in stage one.
    typedef enum logic [1:0] {
        CLS_NORM    = 2'd0,
        CLS_ZERO    = 2'd1,
        CLS_TINY    = 2'd2,
        CLS_SPECIAL = 2'd3
    } cls_t;

    // Rounding direction; the encoding is fixed at the port.
    typedef enum logic [1:0] {
        DIR_NEAR = 2'b00,
        DIR_ZERO = 2'b01,
        DIR_DOWN = 2'b10,
        DIR_UP   = 2'b11
    } dir_t;

    // Kept mantissa width; index into the per-width generate arrays.
    typedef enum logic [1:0] {
        KEEP_EXT = 2'd0,
        KEEP_SGL = 2'd1,
        KEEP_DBL = 2'd2
    } keep_t;

    // Record handed from stage one to stage two.
    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
        cls_t             cls;
        keep_t            keep;
        logic             inc;
        logic             inexact;
    } stage_t;

endpackage

// File: rtl/rnd80_classify.sv
// Splits the operand into fields, sorts it into a class and decodes the
// precision field into a kept width. Purely combinational.
// Assumes: exponent all ones is infinity/NaN, exponent zero is zero/denormal.
module rnd80_classify
    import rnd80_pkg::*;
#(
    parameter int GUARD_W = 8
) (
    input  logic [VAL_W-1:0]   val,
    input  logic [GUARD_W-1:0] ext,
    input  logic [1:0]         prec,
    output logic               sign,
    output logic [EXP_W-1:0]   exp,
    output logic [MAN_W-1:0]   man,
    output cls_t               cls,
    output keep_t              keep
);

    assign sign = val[VAL_W-1];
    assign exp  = val[VAL_W-2 -: EXP_W];
    assign man  = val[MAN_W-1:0];

    // Purpose: sort the operand by its exponent and residue.
    always_comb begin
        if (exp == EXP_TOP)
            cls = CLS_SPECIAL;
        else if (exp == '0)
            cls = ((man == '0) && (ext == '0)) ? CLS_ZERO : CLS_TINY;
        else
            cls = CLS_NORM;
    end

    // Purpose: map the precision code to a kept width; code 11 means extended.
    always_comb begin
        case (prec)
            2'b01:   keep = KEEP_SGL;
            2'b10:   keep = KEEP_DBL;
            default: keep = KEEP_EXT;
        endcase
    end

endmodule

// File: rtl/rnd80_decide.sv
// Stage-one rounding decision: for each kept width it forms the truncated
// mantissa and the last-kept, guard and sticky bits, then selects one set
// and decides whether to add one unit in the last kept place.
// Assumes GUARD_W >= 2 so the extended width also has a sticky field.
module rnd80_decide
    import rnd80_pkg::*;
#(
    parameter int GUARD_W  = 8,
    parameter int SGL_BITS = 24,
    parameter int DBL_BITS = 53
) (
    input  logic               sign,
    input  logic [MAN_W-1:0]   man,
    input  logic [GUARD_W-1:0] ext,
    input  keep_t              keep,
    input  dir_t               dir,
    output logic [MAN_W-1:0]   kept,
    output logic               inc,
    output logic               inexact
);

    localparam int FULL_W = MAN_W + GUARD_W;
    localparam int N_KEEP = 3;

    logic [FULL_W-1:0] full;
    logic [N_KEEP-1:0] lsb_v;
    logic [N_KEEP-1:0] grd_v;
    logic [N_KEEP-1:0] stk_v;
    logic [MAN_W-1:0]  kept_v [N_KEEP];

    logic lsb;
    logic grd;
    logic stk;

    assign full = {man, ext};

    // One slice per supported width.
    for (genvar gi = 0; gi < N_KEEP; gi++) begin : g_width
        localparam int KB   = (gi == 0) ? MAN_W : ((gi == 1) ? SGL_BITS : DBL_BITS);
        localparam int DROP = FULL_W - KB;
        localparam int CUT  = MAN_W - KB;
        localparam logic [MAN_W-1:0] KMASK =
            ~((MAN_W'(1) << CUT) - MAN_W'(1));

        assign lsb_v[gi]  = full[DROP];
        assign grd_v[gi]  = full[DROP-1];
        assign stk_v[gi]  = |full[DROP-2:0];
        assign kept_v[gi] = man & KMASK;
    end

    // Purpose: pick the slice matching the selected width.
    always_comb begin
        lsb  = lsb_v[keep];
        grd  = grd_v[keep];
        stk  = stk_v[keep];
        kept = kept_v[keep];
    end

    assign inexact = grd | stk;

    // Purpose: decide the one-unit increment from direction, sign and residue.
    always_comb begin
        case (dir)
            DIR_NEAR: inc = grd & (stk | lsb);
            DIR_ZERO: inc = 1'b0;
            DIR_DOWN: inc = sign & inexact;
            DIR_UP:   inc = ~sign & inexact;
            default:  inc = 1'b0;
        endcase
    end

endmodule

// File: rtl/rnd80_apply.sv
// Stage-two datapath: adds the chosen unit, renormalises on carry-out,
// saturates to infinity on exponent overflow and builds the output word and
// flags for every operand class. Purely combinational.
// Assumes normal operands carry a set integer bit.
module rnd80_apply
    import rnd80_pkg::*;
#(
    parameter int SGL_BITS = 24,
    parameter int DBL_BITS = 53
) (
    input  stage_t             rec,
    output logic [VAL_W-1:0]   res,
    output logic               res_inx,
    output logic               res_ovf,
    output logic               res_unf
);

    localparam int N_KEEP = 3;

    logic [MAN_W-1:0] ulp_v [N_KEEP];
    logic [MAN_W-1:0] ulp;
    logic [MAN_W:0]   sum;
    logic             carry;
    logic [EXP_W-1:0] exp_n;
    logic [MAN_W-1:0] man_n;
    logic             ovf;

    // Unit in the last kept place for each width.
    for (genvar gi = 0; gi < N_KEEP; gi++) begin : g_ulp
        localparam int KB  = (gi == 0) ? MAN_W : ((gi == 1) ? SGL_BITS : DBL_BITS);
        localparam int CUT = MAN_W - KB;
        assign ulp_v[gi] = MAN_W'(1) << CUT;
    end

    assign ulp = ulp_v[rec.keep];

    // Purpose: add the unit and renormalise a carry into the exponent.
    always_comb begin
        sum   = {1'b0, rec.man} + (rec.inc ? {1'b0, ulp} : '0);
        carry = sum[MAN_W];
        exp_n = rec.exp + EXP_W'(carry);
        man_n = carry ? {1'b1, {(MAN_W-1){1'b0}}} : sum[MAN_W-1:0];
        ovf   = carry && (rec.exp == EXP_BIG);
    end

    // Purpose: assemble the result word and flags per class.
    always_comb begin
        res     = {rec.sign, rec.exp, rec.man};
        res_inx = 1'b0;
        res_ovf = 1'b0;
        res_unf = 1'b0;
        case (rec.cls)
            CLS_TINY: begin
                res     = {rec.sign, {(VAL_W-1){1'b0}}};
                res_inx = 1'b1;
                res_unf = 1'b1;
            end
            CLS_NORM: begin
                if (ovf) begin
                    res     = {rec.sign, EXP_TOP, {MAN_W{1'b0}}};
                    res_inx = 1'b1;
                    res_ovf = 1'b1;
                end else begin
                    res     = {rec.sign, exp_n, man_n};
                    res_inx = rec.inexact;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rnd80_unit.sv
// Two-stage rounder for 80-bit extended-precision results. Stage one
// classifies the operand and decides the increment; stage two applies it.
// Output strobe follows input strobe by two cycles; one operand per cycle.
// Assumes in_ext continues the mantissa below bit 0 and GUARD_W >= 2.
module rnd80_unit
    import rnd80_pkg::*;
#(
    parameter int GUARD_W  = 8,
    parameter int SGL_BITS = 24,
    parameter int DBL_BITS = 53
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [79:0]        in_val,
    input  logic [GUARD_W-1:0] in_ext,
    input  logic [1:0]         in_prec,
    input  logic [1:0]         in_rnd,
    output logic               out_valid,
    output logic [79:0]        out_val,
    output logic               out_inexact,
    output logic               out_overflow,
    output logic               out_underflow
);

    logic             c_sign;
    logic [EXP_W-1:0] c_exp;
    logic [MAN_W-1:0] c_man;
    cls_t             c_cls;
    keep_t            c_keep;
    logic [MAN_W-1:0] c_kept;
    logic             c_inc;
    logic             c_inx;
    stage_t           s1_d;
    stage_t           s1_q;
    logic             s1_vld;

    logic [VAL_W-1:0] r_val;
    logic             r_inx;
    logic             r_ovf;
    logic             r_unf;

    rnd80_classify #(
        .GUARD_W (GUARD_W)
    ) i_classify (
        .val  (in_val),
        .ext  (in_ext),
        .prec (in_prec),
        .sign (c_sign),
        .exp  (c_exp),
        .man  (c_man),
        .cls  (c_cls),
        .keep (c_keep)
    );

    rnd80_decide #(
        .GUARD_W  (GUARD_W),
        .SGL_BITS (SGL_BITS),
        .DBL_BITS (DBL_BITS)
    ) i_decide (
        .sign    (c_sign),
        .man     (c_man),
        .ext     (in_ext),
        .keep    (c_keep),
        .dir     (dir_t'(in_rnd)),
        .kept    (c_kept),
        .inc     (c_inc),
        .inexact (c_inx)
    );

    // Purpose: build the stage-one record; non-normal operands keep their mantissa.
    always_comb begin
        s1_d.sign    = c_sign;
        s1_d.exp     = c_exp;
        s1_d.man     = (c_cls == CLS_NORM) ? c_kept : c_man;
        s1_d.cls     = c_cls;
        s1_d.keep    = c_keep;
        s1_d.inc     = (c_cls == CLS_NORM) && c_inc;
        s1_d.inexact = (c_cls == CLS_NORM) && c_inx;
    end

    // Purpose: stage-one pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_q   <= '0;
        end else begin
            s1_vld <= in_valid;
            s1_q   <= s1_d;
        end
    end

    rnd80_apply #(
        .SGL_BITS (SGL_BITS),
        .DBL_BITS (DBL_BITS)
    ) i_apply (
        .rec     (s1_q),
        .res     (r_val),
        .res_inx (r_inx),
        .res_ovf (r_ovf),
        .res_unf (r_unf)
    );

    // Purpose: stage-two output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_val       <= '0;
            out_inexact   <= 1'b0;
            out_overflow  <= 1'b0;
            out_underflow <= 1'b0;
        end else begin
            out_valid     <= s1_vld;
            out_val       <= r_val;
            out_inexact   <= r_inx;
            out_overflow  <= r_ovf;
            out_underflow <= r_unf;
        end
    end

endmodule

// File: rtl/rnd80_unit_chk.sv
// Property checker for rnd80_unit, attached by bind. Relates outputs to the
// inputs presented two cycles earlier, gated by a cycle count since reset.
module rnd80_unit_chk #(
    parameter int GUARD_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [79:0]        in_val,
    input logic [GUARD_W-1:0] in_ext,
    input logic [1:0]         in_prec,
    input logic [1:0]         in_rnd,
    input logic               out_valid,
    input logic [79:0]        out_val,
    input logic               out_inexact,
    input logic               out_overflow,
    input logic               out_underflow
);

    logic [1:0] since_rst;

    // Purpose: count up to two cycles since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= 2'd0;
        else if (since_rst != 2'd2)
            since_rst <= since_rst + 2'd1;
    end

    p_lag_two_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_special_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && $past(in_valid, 2) && $past(in_val[78:64], 2) == 15'h7FFF)
        |-> (out_val == $past(in_val, 2) && !out_inexact && !out_overflow && !out_underflow));

    p_single_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && $past(in_valid, 2) && $past(in_prec, 2) == 2'b01
         && $past(in_val[78:64], 2) != 15'h7FFF)
        |-> (out_val[39:0] == 40'h0));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && $past(in_valid, 2) && $past(in_rnd, 2) == 2'b01)
        |-> !out_overflow);

    p_overflow_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow)
        |-> (out_inexact && out_val[78:0] == {15'h7FFF, 64'h0}));

    p_flush_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_underflow)
        |-> (out_inexact && out_val[78:0] == 79'h0));

    p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !out_inexact && !out_overflow && !out_underflow));

    // Inputs are observed only through the properties above.
    logic unused_ext;
    assign unused_ext = ^in_ext;

endmodule

bind rnd80_unit rnd80_unit_chk #(
    .GUARD_W (GUARD_W)
) i_rnd80_unit_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_val        (in_val),
    .in_ext        (in_ext),
    .in_prec       (in_prec),
    .in_rnd        (in_rnd),
    .out_valid     (out_valid),
    .out_val       (out_val),
    .out_inexact   (out_inexact),
    .out_overflow  (out_overflow),
    .out_underflow (out_underflow)
);

// File: tb/test_rnd80_unit.sv
`timescale 1ns/1ps
// Bench for rnd80_unit: streams a vector table back-to-back, then runs
// directed checks on reset, strobe latency and reset during flight.
module test_rnd80_unit;

    localparam int GW = 8;
    localparam int NV = 24;

    typedef struct packed {
        logic [79:0]   v;
        logic [GW-1:0] x;
        logic [1:0]    p;
        logic [1:0]    r;
        logic [79:0]   e;
        logic [2:0]    f;   // {inexact, overflow, underflow}
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{ {1'b0,15'h3FFF,64'h8000_0000_0000_0001}, 8'h00, 2'd0, 2'd0, {1'b0,15'h3FFF,64'h8000_0000_0000_0001}, 3'b000 },
        '{ {1'b0,15'h3FFF,64'h8000_0000_0000_0000}, 8'h80, 2'd0, 2'd0, {1'b0,15'h3FFF,64'h8000_0000_0000_0000}, 3'b100 },
        '{ {1'b0,15'h3FFF,64'h8000_0000_0000_0001}, 8'h80, 2'd0, 2'd0, {1'b0,15'h3FFF,64'h8000_0000_0000_0002}, 3'b100 },
        '{ {1'b0,15'h3FFF,64'h8000_0180_0000_0000}, 8'h00, 2'd1, 2'd0, {1'b0,15'h3FFF,64'h8000_0200_0000_0000}, 3'b100 },
        '{ {1'b0,15'h3FFF,64'h8000_0080_0000_0000}, 8'h00, 2'd1, 2'd0, {1'b0,15'h3FFF,64'h8000_0000_0000_0000}, 3'b100 },
        '{ {1'b0,15'h3FFF,64'h8000_01FF_FFFF_FFFF}, 8'hFF, 2'd1, 2'd1, {1'b0,15'h3FFF,64'h8000_0100_0000_0000}, 3'b100 },
        '{ {1'b0,15'h3FFF,64'h8000_0000_0000_0400}, 8'h01, 2'd2, 2'd0, {1'b0,15'h3FFF,64'h8000_0000_0000_0800}, 3'b100 },
        '{ {1'b0,15'h3FFF,64'h8000_0000_0000_0800}, 8'h00, 2'd2, 2'd0, {1'b0,15'h3FFF,64'h8000_0000_0000_0800}, 3'b000 },
        '{ {1'b1,15'h3FFF,64'h8000_0000_0000_0001}, 8'h00, 2'd1, 2'd2, {1'b1,15'h3FFF,64'h8000_0100_0000_0000}, 3'b100 },
        '{ {1'b0,15'h3FFF,64'h8000_0000_0000_0001}, 8'h00, 2'd1, 2'd2, {1'b0,15'h3FFF,64'h8000_0000_0000_0000}, 3'b100 },
        '{ {1'b0,15'h3FFF,64'h8000_0000_0000_0001}, 8'h01, 2'd0, 2'd3, {1'b0,15'h3FFF,64'h8000_0000_0000_0002}, 3'b100 },
        '{ {1'b1,15'h3FFF,64'h8000_0000_0000_0001}, 8'h01, 2'd0, 2'd3, {1'b1,15'h3FFF,64'h8000_0000_0000_0001}, 3'b100 },
        '{ {1'b0,15'h3FFF,64'hFFFF_FF80_0000_0000}, 8'h00, 2'd1, 2'd0, {1'b0,15'h4000,64'h8000_0000_0000_0000}, 3'b100 },
        '{ {1'b0,15'h3FFF,64'hFFFF_FFFF_FFFF_FFFF}, 8'h01, 2'd0, 2'd3, {1'b0,15'h4000,64'h8000_0000_0000_0000}, 3'b100 },
        '{ {1'b0,15'h7FFE,64'hFFFF_FFFF_FFFF_FFFF}, 8'h80, 2'd0, 2'd0, {1'b0,15'h7FFF,64'h0000_0000_0000_0000}, 3'b110 },
        '{ {1'b0,15'h7FFE,64'hFFFF_FFFF_FFFF_FFFF}, 8'h80, 2'd0, 2'd1, {1'b0,15'h7FFE,64'hFFFF_FFFF_FFFF_FFFF}, 3'b100 },
        '{ {1'b1,15'h7FFE,64'hFFFF_FF00_0000_0001}, 8'h00, 2'd1, 2'd2, {1'b1,15'h7FFF,64'h0000_0000_0000_0000}, 3'b110 },
        '{ {1'b0,15'h7FFF,64'hC000_0000_0000_0001}, 8'hFF, 2'd1, 2'd3, {1'b0,15'h7FFF,64'hC000_0000_0000_0001}, 3'b000 },
        '{ {1'b1,15'h7FFF,64'h0000_0000_0000_0000}, 8'h00, 2'd2, 2'd0, {1'b1,15'h7FFF,64'h0000_0000_0000_0000}, 3'b000 },
        '{ {1'b1,15'h0000,64'h0000_0000_0000_0123}, 8'h00, 2'd0, 2'd0, {1'b1,15'h0000,64'h0000_0000_0000_0000}, 3'b101 },
        '{ {1'b0,15'h0000,64'h0000_0000_0000_0000}, 8'h01, 2'd1, 2'd3, {1'b0,15'h0000,64'h0000_0000_0000_0000}, 3'b101 },
        '{ {1'b1,15'h0000,64'h0000_0000_0000_0000}, 8'h00, 2'd0, 2'd0, {1'b1,15'h0000,64'h0000_0000_0000_0000}, 3'b000 },
        '{ {1'b0,15'h3FFF,64'h8000_0000_0000_0001}, 8'h00, 2'd3, 2'd0, {1'b0,15'h3FFF,64'h8000_0000_0000_0001}, 3'b000 },
        '{ {1'b0,15'h3FFF,64'h8000_0000_0000_0001}, 8'h80, 2'd3, 2'd0, {1'b0,15'h3FFF,64'h8000_0000_0000_0002}, 3'b100 }
    };

    // Requirement exercised by each table row.
    localparam string TAG [NV] = '{
        "R1",  "R3",  "R3",  "R2",  "R3",  "R4",  "R2",  "R8",
        "R5",  "R5",  "R5",  "R5",  "R6",  "R6",  "R7",  "R4",
        "R7",  "R9",  "R9",  "R10", "R10", "R10", "R2",  "R2"
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [79:0]   in_val = '0;
    logic [GW-1:0] in_ext = '0;
    logic [1:0]    in_prec = '0;
    logic [1:0]    in_rnd = '0;
    logic          out_valid;
    logic [79:0]   out_val;
    logic          out_inexact;
    logic          out_overflow;
    logic          out_underflow;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    rnd80_unit #(
        .GUARD_W (GW)
    ) i_rnd80_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_val        (in_val),
        .in_ext        (in_ext),
        .in_prec       (in_prec),
        .in_rnd        (in_rnd),
        .out_valid     (out_valid),
        .out_val       (out_val),
        .out_inexact   (out_inexact),
        .out_overflow  (out_overflow),
        .out_underflow (out_underflow)
    );

    task automatic check(input string tag, input logic [83:0] act, input logic [83:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic drive(input bit vld, input int idx);
        in_valid = vld;
        in_val   = TBL[idx].v;
        in_ext   = TBL[idx].x;
        in_prec  = TBL[idx].p;
        in_rnd   = TBL[idx].r;
    endtask

    function automatic logic [83:0] observed();
        return {out_valid, out_val, out_inexact, out_overflow, out_underflow};
    endfunction

    function automatic logic [83:0] wanted(input int idx);
        return {1'b1, TBL[idx].e, TBL[idx].f};
    endfunction

    initial begin
        // R12: quiet outputs while reset is held.
        repeat (4) @(negedge clk);
        check("R12 reset", observed(), 84'h0);
        rst_n = 1'b1;

        // Table walk, one operand per cycle; compare the operand from two steps back (R11).
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2)
                check(TAG[i-2], observed(), wanted(i-2));
            if (i < NV)
                drive(1'b1, i);
            else
                drive(1'b0, 0);
        end

        // R11: a lone operand gives a one-cycle strobe exactly two cycles later.
        @(negedge clk);
        drive(1'b1, 2);
        @(negedge clk);
        drive(1'b0, 0);
        check("R11 early", {83'h0, out_valid}, 84'h0);
        @(negedge clk);
        check("R11 due", observed(), wanted(2));
        @(negedge clk);
        check("R11 after", {83'h0, out_valid}, 84'h0);

        // R12: reset drops an operand already in stage one.
        drive(1'b1, 14);
        @(negedge clk);
        drive(1'b0, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 flush", observed(), 84'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after", observed(), 84'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule